// File: doc/BRIEF.md
# Phase-Lock Mode Control Sequencer

This block decides when a counter-based frequency lock loop is in its locked state and when it falls back to plain counting. It watches four asynchronous levels: a debounced lock-request switch, a time-base reference, a lock-error flag from the analog limit sensing, and a test override that hides that error flag. From these it produces a lock-active flag and a delayed enable for the stall counter and the main counter. It also drives an enable for an external flasher that shows a lost lock, and a two-bit mode code.

A lock is armed only by a falling edge of the time base that arrives while the request is held. An error ends the lock and holds the block in a fault mode, with the flasher on. The fault clears only when the request is released. A new lock then needs the request asserted again and a fresh falling edge of the time base. The counter enable rises a fixed number of clock cycles after the lock becomes valid and drops in the same cycle that the lock ends. Every input passes through a two-stage synchroniser. Reset is synchronous and active high.

Top module: `lms_mode_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, lock_active_o, cnt_en_o and flash_en_o are 0 and mode_o is 2'b00 (count).
- R2: A falling edge of tbase_i while lock_req_i is high sets lock_active_o to 1 and mode_o to 2'b01 (lock), three clock edges after the edge is presented.
- R3: Holding lock_req_i high while tbase_i stays constant, low or high, does not arm the lock. A time base that was already low when the request rose is not an arming edge.
- R4: Releasing lock_req_i drops lock_active_o and returns mode_o to 2'b00 three clock edges later.
- R5: When err_i goes high while locked and err_mask_i is low, flash_en_o goes to 1, lock_active_o goes to 0 and mode_o goes to 2'b10 (fault), all three clock edges later.
- R6: In fault mode, further time-base edges and removal of err_i do not restore the lock. Only releasing lock_req_i, asserting it again and then a new falling edge of the time base do.
- R7: While err_mask_i is high, err_i has no effect: the lock stays active and flash_en_o stays 0.
- R8: cnt_en_o rises exactly DELAY clock cycles after lock_active_o rises.
- R9: cnt_en_o falls in the same cycle as lock_active_o, and it is never high while lock_active_o is low.
- R10: err_i raised while the block is not locked does not set flash_en_o, and it does not disturb a later lock.
- R11: Releasing lock_req_i in fault mode clears flash_en_o and returns mode_o to 2'b00 three clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_req_i | input | 1 | Debounced lock-request switch level (asynchronous) |
| tbase_i | input | 1 | Time-base reference level (asynchronous) |
| err_i | input | 1 | Lock-range error flag (asynchronous) |
| err_mask_i | input | 1 | Test override that hides err_i (asynchronous) |
| lock_active_o | output | 1 | Lock valid: armed and no fault latched |
| cnt_en_o | output | 1 | Delayed enable for the stall and main counters |
| flash_en_o | output | 1 | Lost-lock flasher enable |
| mode_o | output | 2 | 00 count, 01 lock, 10 fault |

## Verification
A wrong armed flag shows as a lock that appears without a time-base edge, or that survives a release, three cycles after the stimulus. A wrong fault latch shows as a flasher that does not light up, or as a lock that comes back after a further time-base edge. A miscounted delay counter shifts the rising edge of cnt_en_o away from the expected cycle, or lets it outlive the lock. The bench sweeps the spacing between request and time-base edge, and the moment of the error across the whole enable delay, and checks the outputs at the exact cycle of each change.

// File: rtl/lms_pkg.sv
package lms_pkg;
  typedef enum logic [1:0] {
    MODE_COUNT = 2'b00,
    MODE_LOCK  = 2'b01,
    MODE_FAULT = 2'b10
  } lms_mode_e;
endpackage

// File: rtl/lms_sync.sv
// Multi-bit bank of independent flop chains for asynchronous levels.
module lms_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= '0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lms_arm_ctrl.sv
// Armed flag and fault latch, both cleared by releasing the request.
module lms_arm_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic req_s,
  input  logic tbase_s,
  input  logic err_s,
  input  logic mask_s,
  output logic armed_o,
  output logic fault_o
);
  logic tb_prev_q;
  logic tb_fall;
  logic err_hit;

  assign tb_fall = tb_prev_q & ~tbase_s;
  assign err_hit = err_s & ~mask_s;

  always_ff @(posedge clk) begin
    if (rst) tb_prev_q <= 1'b0;
    else     tb_prev_q <= tbase_s;
  end

  always_ff @(posedge clk) begin
    if (rst || !req_s)  armed_o <= 1'b0;
    else if (tb_fall)   armed_o <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !req_s)            fault_o <= 1'b0;
    else if (armed_o && err_hit)  fault_o <= 1'b1;
  end
endmodule

// File: rtl/lms_en_delay.sv
// Rising-edge delay of DELAY cycles; falling edge passes at once.
module lms_en_delay #(
  parameter int DELAY = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic valid_i,
  output logic en_o
);
  localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q;
  logic          en_q;

  always_ff @(posedge clk) begin
    if (rst || !valid_i) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (!en_q) begin
      if (cnt_q == LAST) en_q  <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign en_o = en_q & valid_i;
endmodule

// File: rtl/lms_mode_seq.sv
module lms_mode_seq #(
  parameter int DELAY       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lock_req_i,
  input  logic       tbase_i,
  input  logic       err_i,
  input  logic       err_mask_i,
  output logic       lock_active_o,
  output logic       cnt_en_o,
  output logic       flash_en_o,
  output logic [1:0] mode_o
);
  import lms_pkg::*;

  localparam int NIN = 4;

  logic [NIN-1:0] raw, synced;
  logic           armed, fault, lock_valid;
  lms_mode_e      mode;

  assign raw = {err_mask_i, err_i, tbase_i, lock_req_i};

  lms_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw),
    .q_o (synced)
  );

  lms_arm_ctrl u_arm (
    .clk     (clk),
    .rst     (rst),
    .req_s   (synced[0]),
    .tbase_s (synced[1]),
    .err_s   (synced[2]),
    .mask_s  (synced[3]),
    .armed_o (armed),
    .fault_o (fault)
  );

  assign lock_valid = armed & ~fault;

  lms_en_delay #(.DELAY(DELAY)) u_dly (
    .clk     (clk),
    .rst     (rst),
    .valid_i (lock_valid),
    .en_o    (cnt_en_o)
  );

  always_comb begin
    if (fault)      mode = MODE_FAULT;
    else if (armed) mode = MODE_LOCK;
    else            mode = MODE_COUNT;
  end

  assign lock_active_o = lock_valid;
  assign flash_en_o    = fault;
  assign mode_o        = mode;
endmodule

// File: rtl/lms_mode_seq_chk.sv
module lms_mode_seq_chk #(
  parameter int DELAY = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       lock_active_o,
  input logic       cnt_en_o,
  input logic       flash_en_o,
  input logic [1:0] mode_o
);
  localparam int RW = $clog2(DELAY + 2);
  localparam logic [RW-1:0] SAT = RW'(DELAY + 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !lock_active_o) run_q <= '0;
    else if (run_q != SAT)     run_q <= run_q + 1'b1;
  end

  a_r9_en_needs_lock: assert property (@(posedge clk) disable iff (rst)
    cnt_en_o |-> lock_active_o);

  a_r5_flash_excludes_lock: assert property (@(posedge clk) disable iff (rst)
    flash_en_o |-> !lock_active_o);

  a_r5_flash_breaks_lock: assert property (@(posedge clk) disable iff (rst)
    $rose(flash_en_o) |-> $fell(lock_active_o));

  a_r8_en_delay: assert property (@(posedge clk) disable iff (rst)
    $rose(cnt_en_o) |-> (run_q == RW'(DELAY)));

  a_r2_mode_matches_lock: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b01) == lock_active_o);

  a_r11_fault_mode_flash: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b10) == flash_en_o);
endmodule

bind lms_mode_seq lms_mode_seq_chk #(.DELAY(DELAY)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .lock_active_o (lock_active_o),
  .cnt_en_o      (cnt_en_o),
  .flash_en_o    (flash_en_o),
  .mode_o        (mode_o)
);

// File: tb/test_lms_mode_seq.sv
`timescale 1ns/1ps
module test_lms_mode_seq;
  localparam int DELAY = 5;
  localparam int LAT   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, tb = 1'b1, err = 1'b0, mask = 1'b0;
  logic lock, en, flash;
  logic [1:0] mode;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  lms_mode_seq #(.DELAY(DELAY)) i_lms_mode_seq (
    .clk (clk), .rst (rst),
    .lock_req_i (req), .tbase_i (tb), .err_i (err), .err_mask_i (mask),
    .lock_active_o (lock), .cnt_en_o (en), .flash_en_o (flash), .mode_o (mode)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic outs(input string tag, input logic l, input logic e,
                      input logic f, input logic [1:0] m);
    check({tag, " lock"}, {1'b0, lock}, {1'b0, l});
    check({tag, " en"},   {1'b0, en},   {1'b0, e});
    check({tag, " flash"},{1'b0, flash},{1'b0, f});
    check({tag, " mode"}, mode, m);
  endtask

  // Request, wait gap cycles, drop time base; checks arming latency and enable delay.
  task automatic lock_up(input string tag, input int gap);
    tb = 1'b1; tick(LAT + 1);
    req = 1'b1;
    if (gap > 0) tick(gap);
    tb = 1'b0;
    tick(LAT - 1);
    outs({tag, " R2 before"}, 1'b0, 1'b0, 1'b0, 2'b00);
    tick(1);
    outs({tag, " R2 armed"}, 1'b1, 1'b0, 1'b0, 2'b01);
    tick(DELAY - 1);
    check({tag, " R8 en early"}, {1'b0, en}, 2'b00);
    tick(1);
    check({tag, " R8 en on"}, {1'b0, en}, 2'b01);
  endtask

  task automatic release_lock(input string tag);
    req = 1'b0;
    tick(LAT - 1);
    tick(1);
    outs({tag, " R4 released"}, 1'b0, 1'b0, 1'b0, 2'b00);
  endtask

  initial begin
    tick(3);
    outs("R1 in reset", 1'b0, 1'b0, 1'b0, 2'b00);
    rst = 1'b0;
    tick(1);
    outs("R1 after reset", 1'b0, 1'b0, 1'b0, 2'b00);
    tick(4);

    // R2/R8 sweep over request-to-edge spacing.
    for (int g = 0; g < 6; g++) begin
      lock_up($sformatf("sweep g%0d", g), g);
      // R4/R9: lock and enable stay for two edges, then fall together.
      req = 1'b0;
      tick(LAT - 1);
      outs("R4 R9 hold", 1'b1, 1'b1, 1'b0, 2'b01);
      tick(1);
      outs("R4 R9 drop", 1'b0, 1'b0, 1'b0, 2'b00);
      tb = 1'b1; tick(2);
    end

    // R3: time base already low before the request is not an arming edge.
    tb = 1'b0; tick(LAT + 1);
    req = 1'b1; tick(10);
    outs("R3 low tb", 1'b0, 1'b0, 1'b0, 2'b00);
    tb = 1'b1; tick(6);
    outs("R3 high tb", 1'b0, 1'b0, 1'b0, 2'b00);
    tb = 1'b0; tick(LAT);
    outs("R3 then edge", 1'b1, 1'b0, 1'b0, 2'b01);
    release_lock("R3");

    // R5/R9: error at every point across the enable delay window and beyond.
    for (int k = 0; k <= DELAY + 2; k++) begin
      tb = 1'b1; tick(LAT + 1);
      req = 1'b1; tb = 1'b0; tick(LAT);
      if (k > 0) tick(k);
      err = 1'b1;
      tick(LAT - 1);
      check($sformatf("R5 k%0d pre flash", k), {1'b0, flash}, 2'b00);
      tick(1);
      outs($sformatf("R5 R9 k%0d fault", k), 1'b0, 1'b0, 1'b1, 2'b10);
      // R6: error gone and new time-base edges do not restore lock.
      err = 1'b0; tb = 1'b1; tick(4); tb = 1'b0; tick(6);
      outs($sformatf("R6 k%0d stays fault", k), 1'b0, 1'b0, 1'b1, 2'b10);
      req = 1'b0; tick(LAT);
      outs($sformatf("R11 k%0d cleared", k), 1'b0, 1'b0, 1'b0, 2'b00);
    end

    // R6: re-request plus fresh edge relocks after a fault.
    lock_up("R6 relock", 2);

    // R7: masked error leaves lock intact.
    mask = 1'b1; tick(LAT + 1);
    err = 1'b1; tick(12);
    outs("R7 masked", 1'b1, 1'b1, 1'b0, 2'b01);
    err = 1'b0; tick(LAT + 1);
    mask = 1'b0; tick(LAT + 1);
    outs("R7 unmasked idle", 1'b1, 1'b1, 1'b0, 2'b01);
    release_lock("R7");

    // R10: error in count mode is ignored, later lock is normal.
    err = 1'b1; tick(8);
    outs("R10 count err", 1'b0, 1'b0, 1'b0, 2'b00);
    err = 1'b0; tick(LAT + 1);
    lock_up("R10 later lock", 1);
    release_lock("R10");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule